// File: doc/BRIEF.md
# Expansion-Bus DRAM Refresh Cycle Generator

This block sits in a host bridge that drives an ISA-style expansion bus. Some add-in memory cards hold DRAM with no refresh logic of their own, so the bridge must visit each of their rows at a steady rate. The generator keeps a free-running interval timer and an 8-bit row counter. Each time the timer expires it runs one refresh cycle on the bus. The refresh strobe goes low for the whole cycle. The row number appears on the low address lines, with every higher address line driven to zero. The memory read strobe then pulses low for a short, fixed time. No data is taken from the bus.

The bus may be held by a DMA engine for an arbitrarily long transfer. Before each cycle the generator raises a hold request and waits for the DMA side to acknowledge. Once acknowledge is seen, the DMA engine has paused and the refresh takes the bus. The hold is dropped one clock after the refresh strobe returns high. If the timer expires again while a refresh is still waiting, only one refresh stays queued and a sticky overrun flag is set. When no cycle is running, all bus outputs are released through their output enables.

With the defaults and a 14.31818 MHz clock, the interval is 214 clocks (about 14.95 µs), which is inside the 15.6 µs limit. The read pulse is 2 clocks (about 140 ns). Address setup and recovery are each 1 clock.

Top module: `isa_refresh_gen`

## Requirements
- R1: When acknowledge follows the hold request at once, consecutive refresh cycles start (falling edge of `rfsh_n_o`) exactly `INTERVAL_CLKS` clocks apart.
- R2: A refresh cycle starts only in the clock after `dma_hack` was seen high while `dma_hreq` was high. While acknowledge stays low, `dma_hreq` stays high and no strobe is driven.
- R3: `rfsh_n_o` is low, with all output enables high, for exactly `SETUP_CLKS + PULSE_CLKS + RECOVER_CLKS` clocks per cycle.
- R4: During a cycle, `sa_o[ADDR_W-1:ROW_W]` is zero and `sa_o` does not change.
- R5: After `rfsh_n_o` falls, `memr_n_o` stays high for `SETUP_CLKS` clocks before it goes low.
- R6: `memr_n_o` is low for exactly `PULSE_CLKS` clocks. It then stays high for `RECOVER_CLKS` clocks while `rfsh_n_o` is still low.
- R7: `sa_o[ROW_W-1:0]` carries the row number. The row number is 0 for the first cycle after reset and rises by one after each cycle, wrapping from 255 to 0.
- R8: `dma_hreq` is still high in the first clock with `rfsh_n_o` high again. It is low in the clock after that.
- R9: Whenever no cycle runs, `rfsh_oe`, `memr_oe` and `sa_oe` are low, `rfsh_n_o` and `memr_n_o` are high, and `sa_o` is zero.
- R10: An interval expiry while a refresh is still pending sets `overrun_o`, which stays high until reset. Stacked expiries produce one refresh only, and the next one follows the regular interval schedule.
- R11: During reset, `dma_hreq`, all output enables, `sa_o` and `overrun_o` are 0, and both strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_hack | input | 1 | Hold acknowledge from the DMA engine |
| dma_hreq | output | 1 | Hold request to the DMA engine |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| rfsh_oe | output | 1 | Output enable for the refresh strobe |
| memr_n_o | output | 1 | Memory read strobe, active low |
| memr_oe | output | 1 | Output enable for the memory read strobe |
| sa_o | output | ADDR_W | Address lines; low ROW_W bits carry the row |
| sa_oe | output | 1 | Output enable for the address lines |
| overrun_o | output | 1 | Sticky flag: interval expired while a refresh was pending |

## Verification
The hardest situation to reach is a refresh that stays queued across several interval expiries. The bench creates it by holding acknowledge low for more than two full intervals. Acknowledge is then granted a few clocks after a tick, at a moment computed from the timing of earlier cycles. This lets the bench check that exactly one delayed refresh happens and that the next one lands on the original tick schedule. A full sweep of more than 256 cycles walks the row counter through its wrap.

// File: rtl/isa_rfsh_pkg.sv
// Package: shared types for the refresh cycle generator.
// Assumes: one sequencer state encoding is shared by the sequencer, the top
// level output decode and the bound checker.
package isa_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REQUEST    = 3'd1,
        ST_ADDR_SETUP = 3'd2,
        ST_READ_PULSE = 3'd3,
        ST_RECOVER    = 3'd4
    } rfsh_state_e;

    // Largest of three positive lengths; used to size the phase counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: free-running interval timer.
// Does: raises tick_o for one clock every INTERVAL_CLKS clocks.
// Assumes: INTERVAL_CLKS >= 2; the timer never stops, so the tick schedule
// does not depend on how long bus arbitration takes.
module rfsh_interval_timer #(
    parameter int INTERVAL_CLKS = 214
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (INTERVAL_CLKS > 1) ? $clog2(INTERVAL_CLKS) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CLKS - 1);

    logic [CW-1:0] cnt_q;

    // Count down and reload on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (cnt_q == '0)
            cnt_q <= RELOAD;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = (cnt_q == '0);

endmodule

// File: rtl/rfsh_row_counter.sv
// Module: refresh row counter.
// Does: holds the row for the next refresh cycle and adds one on advance_i.
// Assumes: advance_i pulses once, at the end of each completed cycle; the
// count wraps naturally at 2**ROW_W.
module rfsh_row_counter #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    // Step the row after each finished refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (advance_i)
            row_q <= row_q + 1'b1;
    end

    assign row_o = row_q;

endmodule

// File: rtl/rfsh_sequencer.sv
// Module: refresh cycle sequencer with DMA hold handshake.
// Does: queues interval ticks, requests the bus, waits for acknowledge, then
// steps through address setup, read pulse and recovery; flags overruns.
// Assumes: hack_i is meaningful only while hreq_o is high; every timed phase
// lasts at least one clock.
module rfsh_sequencer
    import isa_rfsh_pkg::*;
#(
    parameter int SETUP_CLKS   = 1,
    parameter int PULSE_CLKS   = 2,
    parameter int RECOVER_CLKS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        hack_i,
    output rfsh_state_e state_o,
    output logic        hreq_o,
    output logic        done_o,
    output logic        overrun_o
);
    localparam int LONGEST = max3(SETUP_CLKS, PULSE_CLKS, RECOVER_CLKS);
    localparam int PW      = $clog2(LONGEST + 1);

    rfsh_state_e   st_q, st_d;
    logic [PW-1:0] ph_q;
    logic          pend_q, rel_q, ovr_q;
    logic          start, last_ph, timed;

    // Mark the final clock of the current timed phase.
    always_comb begin
        timed   = 1'b1;
        last_ph = 1'b0;
        case (st_q)
            ST_ADDR_SETUP: last_ph = (ph_q == PW'(SETUP_CLKS - 1));
            ST_READ_PULSE: last_ph = (ph_q == PW'(PULSE_CLKS - 1));
            ST_RECOVER:    last_ph = (ph_q == PW'(RECOVER_CLKS - 1));
            default:       timed   = 1'b0;
        endcase
    end

    assign start = (st_q == ST_REQUEST) && hack_i;

    // Next-state decision for the cycle sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:       if (pend_q && !rel_q) st_d = ST_REQUEST;
            ST_REQUEST:    if (hack_i)           st_d = ST_ADDR_SETUP;
            ST_ADDR_SETUP: if (last_ph)          st_d = ST_READ_PULSE;
            ST_READ_PULSE: if (last_ph)          st_d = ST_RECOVER;
            ST_RECOVER:    if (last_ph)          st_d = ST_IDLE;
            default:                             st_d = ST_IDLE;
        endcase
    end

    // State register and per-phase clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            if (!timed || st_d != st_q)
                ph_q <= '0;
            else
                ph_q <= ph_q + 1'b1;
        end
    end

    // Pending request: set by a tick, cleared when a cycle takes the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= tick_i | (pend_q & ~start);
    end

    // Sticky overrun: a tick arrived while a request was still waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (tick_i && pend_q && !start)
            ovr_q <= 1'b1;
    end

    // Keep the hold asserted for one clock after the strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rel_q <= 1'b0;
        else
            rel_q <= done_o;
    end

    assign done_o    = (st_q == ST_RECOVER) && last_ph;
    assign hreq_o    = (st_q != ST_IDLE) || rel_q;
    assign overrun_o = ovr_q;
    assign state_o   = st_q;

endmodule

// File: rtl/isa_refresh_gen.sv
// Module: top level of the expansion-bus DRAM refresh cycle generator.
// Does: joins timer, row counter and sequencer, and decodes the bus strobes,
// address and output enables from the sequencer state.
// Assumes: clk is the bus oscillator; output enables drive external
// tri-state buffers; ADDR_W > ROW_W.
module isa_refresh_gen
    import isa_rfsh_pkg::*;
#(
    parameter int INTERVAL_CLKS = 214,
    parameter int SETUP_CLKS    = 1,
    parameter int PULSE_CLKS    = 2,
    parameter int RECOVER_CLKS  = 1,
    parameter int ROW_W         = 8,
    parameter int ADDR_W        = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_hack,
    output logic              dma_hreq,
    output logic              rfsh_n_o,
    output logic              rfsh_oe,
    output logic              memr_n_o,
    output logic              memr_oe,
    output logic [ADDR_W-1:0] sa_o,
    output logic              sa_oe,
    output logic              overrun_o
);
    localparam int HIGH_W = ADDR_W - ROW_W;

    logic             tick;
    logic             done;
    logic             on_bus;
    logic [ROW_W-1:0] row_q;
    rfsh_state_e      state;

    rfsh_interval_timer #(
        .INTERVAL_CLKS(INTERVAL_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rfsh_row_counter #(
        .ROW_W(ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (done),
        .row_o     (row_q)
    );

    rfsh_sequencer #(
        .SETUP_CLKS  (SETUP_CLKS),
        .PULSE_CLKS  (PULSE_CLKS),
        .RECOVER_CLKS(RECOVER_CLKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .hack_i    (dma_hack),
        .state_o   (state),
        .hreq_o    (dma_hreq),
        .done_o    (done),
        .overrun_o (overrun_o)
    );

    // The bus belongs to the refresh cycle from address setup to recovery end.
    always_comb begin
        on_bus = (state == ST_ADDR_SETUP) || (state == ST_READ_PULSE) ||
                 (state == ST_RECOVER);
    end

    assign rfsh_n_o = ~on_bus;
    assign rfsh_oe  = on_bus;
    assign memr_n_o = ~(state == ST_READ_PULSE);
    assign memr_oe  = on_bus;
    assign sa_oe    = on_bus;
    assign sa_o     = on_bus ? {{HIGH_W{1'b0}}, row_q} : '0;

endmodule

// Checker: protocol properties of the refresh generator, bound to the top.
module rfsh_checker #(
    parameter int ROW_W  = 8,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_hack,
    input logic              dma_hreq,
    input logic              rfsh_n_o,
    input logic              rfsh_oe,
    input logic              memr_n_o,
    input logic              memr_oe,
    input logic [ADDR_W-1:0] sa_o,
    input logic              sa_oe,
    input logic              overrun_o,
    input logic [ROW_W-1:0]  row_q
);
    AST_START_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rfsh_n_o) |-> $past(dma_hack && dma_hreq)); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sa_oe |-> (sa_o[ADDR_W-1:ROW_W] == '0)); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_n_o && $past(!rfsh_n_o)) |-> $stable(sa_o)); // R4
    AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(memr_n_o) |-> $past(!rfsh_n_o)); // R5
    AST_READ_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !memr_n_o |-> !rfsh_n_o); // R6
    AST_RECOVER_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(memr_n_o) |-> !rfsh_n_o); // R6
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q != $past(row_q)) |-> (row_q == $past(row_q) + 1'b1)); // R7
    AST_HOLD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_n_o) |-> dma_hreq); // R8
    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_n_o) |=> !dma_hreq); // R8
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_hreq |-> (!rfsh_oe && !memr_oe && !sa_oe)); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o); // R10
endmodule

bind isa_refresh_gen rfsh_checker #(
    .ROW_W (ROW_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_hack (dma_hack),
    .dma_hreq (dma_hreq),
    .rfsh_n_o (rfsh_n_o),
    .rfsh_oe  (rfsh_oe),
    .memr_n_o (memr_n_o),
    .memr_oe  (memr_oe),
    .sa_o     (sa_o),
    .sa_oe    (sa_oe),
    .overrun_o(overrun_o),
    .row_q    (row_q)
);

// File: tb/sim_isa_refresh_gen.sv
`timescale 1ns/1ps
// Bench: sweeps the row counter through its wrap with immediate grants, then
// stalls the DMA acknowledge across several intervals.
module sim_isa_refresh_gen;
    localparam int INTERVAL = 20;
    localparam int SETUP    = 2;
    localparam int PULSE    = 3;
    localparam int RECOVER  = 2;
    localparam int ROW_W    = 8;
    localparam int ADDR_W   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              grant_en = 1'b1;
    logic              dma_hack;
    logic              dma_hreq;
    logic              rfsh_n_o, rfsh_oe, memr_n_o, memr_oe, sa_oe, overrun_o;
    logic [ADDR_W-1:0] sa_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit wd_hit = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // The DMA side grants the hold whenever the bench allows it.
    assign dma_hack = dma_hreq & grant_en;

    isa_refresh_gen #(
        .INTERVAL_CLKS(INTERVAL), .SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE),
        .RECOVER_CLKS(RECOVER), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .dma_hack(dma_hack), .dma_hreq(dma_hreq),
        .rfsh_n_o(rfsh_n_o), .rfsh_oe(rfsh_oe), .memr_n_o(memr_n_o),
        .memr_oe(memr_oe), .sa_o(sa_o), .sa_oe(sa_oe), .overrun_o(overrun_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Follow one refresh cycle from its start; entered at a falling clock edge.
    task automatic one_cycle(input int exp_row, input int exp_fall, output int fall);
        int s, p, r;
        logic [ADDR_W-1:0] addr;
        while (rfsh_n_o && !wd_hit) @(negedge clk);
        fall = cyc;
        if (exp_fall >= 0) chk(fall == exp_fall, "R1 start cycle", fall, exp_fall);
        chk(dma_hreq == 1'b1, "R2 hold during cycle", int'(dma_hreq), 1);
        chk(int'(sa_o[ROW_W-1:0]) == exp_row, "R7 row", int'(sa_o[ROW_W-1:0]), exp_row);
        chk(sa_o[ADDR_W-1:ROW_W] == '0, "R4 upper bits", int'(sa_o[ADDR_W-1:ROW_W]), 0);
        chk(rfsh_oe && memr_oe && sa_oe, "R3 enables", int'({rfsh_oe, memr_oe, sa_oe}), 7);
        addr = sa_o;
        s = 0; p = 0; r = 0;
        while (memr_n_o && !rfsh_n_o && !wd_hit) begin s++; @(negedge clk); end
        chk(s == SETUP, "R5 setup clocks", s, SETUP);
        while (!memr_n_o && !wd_hit) begin
            p++;
            if (sa_o != addr) chk(1'b0, "R4 address moved", int'(sa_o), int'(addr));
            @(negedge clk);
        end
        chk(p == PULSE, "R6 pulse clocks", p, PULSE);
        while (!rfsh_n_o && !wd_hit) begin
            r++;
            if (sa_o != addr) chk(1'b0, "R4 address moved", int'(sa_o), int'(addr));
            @(negedge clk);
        end
        chk(r == RECOVER, "R6 recovery clocks", r, RECOVER);
        chk(s + p + r == SETUP + PULSE + RECOVER, "R3 strobe length", s + p + r,
            SETUP + PULSE + RECOVER);
        chk(dma_hreq == 1'b1, "R8 hold tail", int'(dma_hreq), 1);
        chk(!rfsh_oe && !memr_oe && !sa_oe && sa_o == '0 && memr_n_o, "R9 released",
            int'({rfsh_oe, memr_oe, sa_oe}), 0);
        @(negedge clk);
        chk(dma_hreq == 1'b0, "R8 hold dropped", int'(dma_hreq), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        wd_hit = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f, prev, f0, g;
        repeat (3) @(negedge clk);
        // R11 reset values
        chk(!dma_hreq && !rfsh_oe && !memr_oe && !sa_oe && !overrun_o, "R11 low outputs",
            int'({dma_hreq, rfsh_oe, memr_oe, sa_oe, overrun_o}), 0);
        chk(rfsh_n_o && memr_n_o && sa_o == '0, "R11 strobes high",
            int'({rfsh_n_o, memr_n_o}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        prev = -1;
        // Sweep every row and past the wrap: R1, R3-R9, R7 wrap.
        for (int k = 0; k < 258; k++) begin
            one_cycle(k % 256, (prev < 0) ? -1 : prev + INTERVAL, f);
            prev = f;
        end
        chk(overrun_o == 1'b0, "R10 no overrun when granted", int'(overrun_o), 0);
        // Stall the acknowledge across three ticks.
        f0 = prev;
        grant_en = 1'b0;
        g = f0 + 3 * INTERVAL + 2;
        while (cyc < g && !wd_hit) @(negedge clk);
        chk(overrun_o == 1'b1, "R10 overrun set", int'(overrun_o), 1);
        chk(dma_hreq && rfsh_n_o && !rfsh_oe, "R2 waits for grant",
            int'({dma_hreq, rfsh_n_o, rfsh_oe}), 6);
        grant_en = 1'b1;
        one_cycle(258 % 256, g + 1, f);
        one_cycle(259 % 256, f0 + 4 * INTERVAL, f);
        chk(overrun_o == 1'b1, "R10 overrun sticky", int'(overrun_o), 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule